// File: doc/BRIEF.md
# Fly-by Four-Channel DMA Controller

This block moves blocks of words between an I/O port and memory without the data ever passing through it. The controller only sequences the bus: it drives the memory address and pulses a memory strobe and an I/O strobe together, so the peripheral and memory exchange the word directly on the shared data bus.

Software programs each of four channels with a start address, a word count (number of words minus one) and a direction bit. When a device raises its request line, the controller picks the highest-priority requester. It then asks the processor for the bus with a hold request and waits for hold acknowledge. After that it acknowledges the device and runs the block one word per cycle. When the count is used up it drops the hold request and sets a per-channel done flag, which raises the interrupt line until software reads the status.

Top module: `dma_flyby`

## Requirements
- R1: After reset, hrq, every dack bit, all four strobes, irq and every tc_status bit are low.
- R2: One cycle after a request is seen while idle, hrq is high. No dack bit and no strobe is active until hlda is high.
- R3: When several dreq lines are high together, the lowest-numbered channel is served first. The others are served one after another in the same order after it.
- R4: Direction bit 0 (memory to device) asserts mem_rd and io_wr together. Direction bit 1 (device to memory) asserts io_rd and mem_wr together. During each word, dack is one-hot on the active channel.
- R5: The first word uses the programmed start address, and each later word uses the previous address plus one, wrapping modulo 2^16.
- R6: A programmed count of N moves exactly N+1 words, so a count of 0 moves one word.
- R7: In the cycle after the last word, hrq is low, tc_status holds a 1 at the finished channel's bit position, and irq is high.
- R8: A one-cycle stat_rd pulse clears every tc_status bit, and irq is low in the following cycle.
- R9: While hlda is low during a block, no strobe is active and the address does not advance. The block resumes at the next address when hlda returns.
- R10: Configuration writes are ignored while hrq is high.
- R11: cfg_sel selects the target register: 0 is the start address, 1 is the count, and 2 is the direction (cfg_wdata bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel targeted by the write |
| cfg_sel | input | 2 | Register select (0 address, 1 count, 2 direction) |
| cfg_wdata | input | 16 | Write data |
| stat_rd | input | 1 | Status read pulse, clears the done flags |
| tc_status | output | 4 | Per-channel done flags |
| irq | output | 1 | Completion interrupt, high while any flag is set |
| dreq | input | 4 | Device request lines |
| dack | output | 4 | Device acknowledge lines |
| hrq | output | 1 | Bus hold request to the processor |
| hlda | input | 1 | Bus hold acknowledge from the processor |
| mem_addr | output | 16 | Memory address for the current word |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |

## Verification
hrq is registered and rises one cycle after the request is sampled. dack follows one cycle after hlda is sampled high. Strobes and the address for a word appear combinationally in any cycle where the block is moving and hlda is high. The done flag, the interrupt and the fall of hrq appear one cycle after the last word. The bench drives inputs on the falling edge and samples shortly after it, so each registered result is read exactly one clock after its cause. A scoreboard queue holds the expected word sequence, and the monitor pops one entry for every observed strobe cycle. Each entry carries a last-word mark, so the completion check lands in the cycle right after that word.

// File: rtl/dma_pkg.sv
package dma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOLD = 2'd1,
      ST_MOVE = 2'd2
   } seq_state_t;

   localparam logic [1:0] SEL_ADDR  = 2'd0;
   localparam logic [1:0] SEL_COUNT = 2'd1;
   localparam logic [1:0] SEL_DIR   = 2'd2;

   localparam logic DIR_MEM2IO = 1'b0;
   localparam logic DIR_IO2MEM = 1'b1;
endpackage

// File: rtl/dma_chan_reg.sv
module dma_chan_reg #(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_addr,
   input  logic          wr_cnt,
   input  logic          wr_dir,
   input  logic [AW-1:0] addr_in,
   input  logic [CW-1:0] cnt_in,
   input  logic          dir_in,
   input  logic          step,
   output logic [AW-1:0] addr_q,
   output logic [CW-1:0] cnt_q,
   output logic          dir_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
         dir_q  <= 1'b0;
      end else begin
         if (wr_addr)   addr_q <= addr_in;
         else if (step) addr_q <= addr_q + AW'(1);
         if (wr_cnt)    cnt_q  <= cnt_in;
         else if (step) cnt_q  <= cnt_q - CW'(1);
         if (wr_dir)    dir_q  <= dir_in;
      end
   end

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr_addr) |=> addr_q == $past(addr_q) + AW'(1)); // R5
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr_cnt) |=> cnt_q == $past(cnt_q) - CW'(1)); // R6
endmodule

// File: rtl/dma_prio.sv
module dma_prio #(
   parameter int N_CH = 4,
   localparam int IDXW = $clog2(N_CH)
) (
   input  logic [N_CH-1:0] req,
   output logic            gnt_valid,
   output logic [IDXW-1:0] gnt_idx
);
   always_comb begin
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      for (int i = N_CH - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt_valid = 1'b1;
            gnt_idx   = IDXW'(i);
         end
      end
   end

   always_comb begin
      if (gnt_valid) assert (req[gnt_idx]); // R3
   end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
   import dma_pkg::*;
#(
   parameter int IDXW = 2,
   parameter int CW   = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_any,
   input  logic [IDXW-1:0] win_idx,
   input  logic            hlda,
   input  logic [CW-1:0]   cur_cnt,
   output logic            hrq,
   output logic [IDXW-1:0] act_idx,
   output logic            moving,
   output logic            step,
   output logic            done
);
   seq_state_t state_q;

   assign hrq    = (state_q != ST_IDLE);
   assign moving = (state_q == ST_MOVE);
   assign step   = moving && hlda;
   assign done   = step && (cur_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         act_idx <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_any) begin
               state_q <= ST_HOLD;
               act_idx <= win_idx;
            end
            ST_HOLD: if (hlda) state_q <= ST_MOVE;
            ST_MOVE: if (done) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_HRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (moving && !done) |=> hrq); // R7
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !hrq); // R7
   AST_REQ_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hrq && req_any) |=> hrq && !moving); // R2
endmodule

// File: rtl/dma_flyby.sv
module dma_flyby
   import dma_pkg::*;
#(
   parameter int N_CH   = 4,
   parameter int AW     = 16,
   parameter int CW     = 16,
   parameter int DATA_W = 16,
   localparam int IDXW  = $clog2(N_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDXW-1:0]   cfg_ch,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              stat_rd,
   output logic [N_CH-1:0]   tc_status,
   output logic              irq,
   input  logic [N_CH-1:0]   dreq,
   output logic [N_CH-1:0]   dack,
   output logic              hrq,
   input  logic              hlda,
   output logic [AW-1:0]     mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              io_rd,
   output logic              io_wr
);
   if (N_CH < 2 || N_CH > 16) begin : g_bad_nch
      $error("N_CH must lie in 2..16");
   end
   if (DATA_W < AW || DATA_W < CW) begin : g_bad_dw
      $error("DATA_W must cover AW and CW");
   end

   logic [AW-1:0]   addr_arr [N_CH];
   logic [CW-1:0]   cnt_arr  [N_CH];
   logic [N_CH-1:0] dir_arr;
   logic            win_valid, moving, step, done;
   logic [IDXW-1:0] win_idx, act_idx;
   logic [N_CH-1:0] tc_q;
   logic            cfg_ok;

   assign cfg_ok = cfg_we && !hrq;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic hit;
      assign hit = cfg_ok && (cfg_ch == IDXW'(c));
      dma_chan_reg #(.AW(AW), .CW(CW)) u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_addr (hit && cfg_sel == SEL_ADDR),
         .wr_cnt  (hit && cfg_sel == SEL_COUNT),
         .wr_dir  (hit && cfg_sel == SEL_DIR),
         .addr_in (cfg_wdata[AW-1:0]),
         .cnt_in  (cfg_wdata[CW-1:0]),
         .dir_in  (cfg_wdata[0]),
         .step    (step && act_idx == IDXW'(c)),
         .addr_q  (addr_arr[c]),
         .cnt_q   (cnt_arr[c]),
         .dir_q   (dir_arr[c])
      );
      assign dack[c] = moving && (act_idx == IDXW'(c));
   end

   dma_prio #(.N_CH(N_CH)) u_prio (
      .req       (dreq),
      .gnt_valid (win_valid),
      .gnt_idx   (win_idx)
   );

   dma_seq #(.IDXW(IDXW), .CW(CW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_any (win_valid),
      .win_idx (win_idx),
      .hlda    (hlda),
      .cur_cnt (cnt_arr[act_idx]),
      .hrq     (hrq),
      .act_idx (act_idx),
      .moving  (moving),
      .step    (step),
      .done    (done)
   );

   assign mem_addr = moving ? addr_arr[act_idx] : '0;
   assign mem_rd   = step && (dir_arr[act_idx] == DIR_MEM2IO);
   assign io_wr    = step && (dir_arr[act_idx] == DIR_MEM2IO);
   assign io_rd    = step && (dir_arr[act_idx] == DIR_IO2MEM);
   assign mem_wr   = step && (dir_arr[act_idx] == DIR_IO2MEM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_q <= '0;
      end else begin
         for (int c = 0; c < N_CH; c++) begin
            if (done && act_idx == IDXW'(c)) tc_q[c] <= 1'b1;
            else if (stat_rd)                tc_q[c] <= 1'b0;
         end
      end
   end

   assign tc_status = tc_q;
   assign irq       = |tc_q;

   AST_DACK_NEEDS_HRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |-> hrq); // R2
   AST_STROBE_NEEDS_HLDA: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr || io_rd || io_wr) |-> hlda); // R9
   AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr) && !(io_rd && io_wr)); // R4
   AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> irq); // R7
   AST_TC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !done) |=> (tc_status == '0)); // R8
   AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack)); // R4
endmodule

// File: tb/tb_dma_flyby.sv
module tb_dma_flyby;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      int          ch;
      logic [15:0] addr;
      logic        dir;
      bit          last;
   } word_t;

   logic        clk = 0, rst_n = 0;
   logic        cfg_we = 0, stat_rd = 0, hlda = 0;
   logic [1:0]  cfg_ch = 0, cfg_sel = 0;
   logic [15:0] cfg_wdata = 0;
   logic [3:0]  dreq = 0;
   logic [3:0]  tc_status, dack;
   logic        irq, hrq, mem_rd, mem_wr, io_rd, io_wr;
   logic [15:0] mem_addr;

   int    n_run = 0, n_fail = 0, words_seen = 0, lat = 0;
   bit    hold_off = 0, pend_done = 0;
   int    pend_ch = 0;
   word_t exp_q[$];

   dma_flyby dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .stat_rd(stat_rd),
      .tc_status(tc_status), .irq(irq), .dreq(dreq), .dack(dack),
      .hrq(hrq), .hlda(hlda), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // processor side: grants the bus two cycles after a hold request
   always @(negedge clk) begin
      if (!hrq || hold_off) begin
         hlda = 0;
         lat  = 0;
      end else if (lat >= 2) hlda = 1;
      else lat++;
   end

   // devices drop their request once acknowledged
   always @(negedge clk) begin
      for (int i = 0; i < 4; i++) if (dack[i]) dreq[i] = 0;
   end

   // monitor: pops one expected word per strobe cycle
   initial forever begin
      logic [3:0] strb, exp_strb;
      word_t e;
      @(negedge clk);
      #1;
      if (rst_n) begin
         strb = {mem_rd, mem_wr, io_rd, io_wr};
         if (pend_done) begin
            chk(hrq == 0, "R7", "hrq after last word", 32'(hrq), 0);
            chk(irq == 1 && tc_status[pend_ch] == 1, "R7", "tc/irq after last word",
                32'({irq, tc_status}), 32'({1'b1, 4'(1 << pend_ch)}));
            pend_done = 0;
         end
         if (!hlda && strb != 0)
            chk(0, "R9", "strobe without hlda", 32'(strb), 0);
         if (strb != 0) begin
            words_seen++;
            if (exp_q.size() == 0) chk(0, "R6", "unexpected word", 32'(mem_addr), 0);
            else begin
               e = exp_q.pop_front();
               exp_strb = (e.dir == 1'b0) ? 4'b1001 : 4'b0110;
               chk(mem_addr == e.addr, "R5/R11", "word address", 32'(mem_addr), 32'(e.addr));
               chk(strb == exp_strb, "R4", "strobe pair", 32'(strb), 32'(exp_strb));
               chk(dack == 4'(1 << e.ch), "R3/R4", "dack channel", 32'(dack), 32'(1 << e.ch));
               if (e.last) begin
                  pend_done = 1;
                  pend_ch   = e.ch;
               end
            end
         end
      end
   end

   task automatic cfg_write(input int ch, input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_ch = 2'(ch); cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic program_ch(input int ch, input logic [15:0] a, input logic [15:0] n,
                             input logic dir);
      cfg_write(ch, 2'd0, a);
      cfg_write(ch, 2'd1, n);
      cfg_write(ch, 2'd2, {15'd0, dir});
   endtask

   task automatic push_block(input int ch, input logic [15:0] a, input int n,
                             input logic dir);
      for (int k = 0; k <= n; k++)
         exp_q.push_back('{ch: ch, addr: 16'(a + 16'(k)), dir: dir, last: (k == n)});
   endtask

   task automatic wait_idle();
      int guard = 0;
      repeat (3) @(negedge clk);
      while ((hrq || exp_q.size() != 0 || pend_done) && guard < 400) begin
         @(negedge clk);
         guard++;
      end
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R6", "words left unmoved", 32'(exp_q.size()), 0);
   endtask

   task automatic read_status(input logic [3:0] exp_tc);
      @(negedge clk);
      #2;
      chk(tc_status == exp_tc, "R7", "done flags before read", 32'(tc_status), 32'(exp_tc));
      stat_rd = 1;
      @(negedge clk);
      stat_rd = 0;
      #2;
      chk(tc_status == 0 && irq == 0, "R8", "flags after read", 32'({irq, tc_status}), 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      chk(0, "R1", "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk({hrq, dack, mem_rd, mem_wr, io_rd, io_wr, irq, tc_status} == 0, "R1",
          "reset outputs", 32'({hrq, dack, irq, tc_status}), 0);
      @(negedge clk);
      rst_n = 1;

      // R11 R6: four words memory to device on channel 2
      program_ch(2, 16'h1000, 16'd3, 1'b0);
      push_block(2, 16'h1000, 3, 1'b0);
      @(negedge clk);
      dreq[2] = 1;
      @(negedge clk);
      #1;
      chk(hrq == 1, "R2", "hrq one cycle after request", 32'(hrq), 1);
      chk(dack == 0, "R2", "dack before hlda", 32'(dack), 0);
      // R10: rewrite channel 2 address while the bus is held
      cfg_write(2, 2'd0, 16'h5555);
      wait_idle();
      read_status(4'b0100);

      // R5 wrap and R4 device-to-memory on channel 0
      program_ch(0, 16'hFFFF, 16'd1, 1'b1);
      push_block(0, 16'hFFFF, 1, 1'b1);
      @(negedge clk);
      dreq[0] = 1;
      wait_idle();
      read_status(4'b0001);

      // R3 priority: channels 1 and 3 together; R6 count 0 on channel 3
      program_ch(1, 16'h0200, 16'd1, 1'b0);
      program_ch(3, 16'h0300, 16'd0, 1'b1);
      push_block(1, 16'h0200, 1, 1'b0);
      push_block(3, 16'h0300, 0, 1'b1);
      @(negedge clk);
      dreq = 4'b1010;
      wait_idle();
      read_status(4'b1010);

      // R9 hold acknowledge removed mid-block
      program_ch(2, 16'h0040, 16'd4, 1'b1);
      push_block(2, 16'h0040, 4, 1'b1);
      base = words_seen;
      @(negedge clk);
      dreq[2] = 1;
      wait (words_seen >= base + 2);
      @(posedge clk);
      hold_off = 1;
      repeat (4) @(posedge clk);
      #1;
      chk(words_seen == base + 2 || words_seen == base + 3, "R9", "words during pause",
          32'(words_seen - base), 2);
      hold_off = 0;
      wait_idle();
      read_status(4'b0100);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule